// File: doc/BRIEF.md
# Duplicated SEC/DED Instruction Store with Whole-Memory Repair

This block holds a processor's program as 22-bit single-error-correcting, double-error-detecting codewords. Each 16-bit instruction carries six check bits. Every codeword is split across two 11-bit memory banks, one for the high half and one for the low half. The whole encoded store exists twice, as copy 0 and copy 1. Each fetch reads both copies through their first memory port. A decoder per copy classifies its word as clean, corrected (one flipped bit) or failed (two flipped bits). The instruction is taken from a copy that did not fail.

When a fetched word shows a corrected or a failed result in either copy, a repair engine starts. It walks every address through the second memory port. It reads the good copy, corrects the word, re-encodes it and writes it into the other copy. The repair engine moves one address every two clock cycles. Fetches keep running while a repair is in progress. A load port writes raw codewords into one copy. It is used to place the program and to model upsets. Load writes are ignored while a repair is running.

The fetch request carries a valid strobe only. It has no ready signal because the store always accepts a request and answers it a fixed single cycle later. The consumer of `instr_valid` must take the result in the cycle it is shown: there is no back-pressure on either side.

Top module: `dup_secded_imem`

## Requirements
- R1: Codeword layout: bit p of the 22-bit word is position p. The data bits, least significant first, fill positions 3, 5, 6, 7, 9 to 15 and 17 to 21 in ascending order. The check bit at position 2^k (k = 0..4) gives even parity over all positions 1..21 whose index has bit k set. Bit 0 gives even parity over the whole word. Bits 21..11 go to the high bank and bits 10..0 to the low bank. `load_code` uses this same layout.
- R2: A fetch request sampled at a clock edge produces `instr_valid` high after the next edge, with the stored word on `instr`. For clean copies, both error flag pairs read 0.
- R3: A single flipped bit at any of the 22 positions in one copy returns the original word and sets that copy's bit of `err_corr` (bit 0 for copy 0, bit 1 for copy 1).
- R4: Two flipped bits in one copy set that copy's bit of `err_uncorr`, and the instruction still comes correct from the other copy.
- R5: The instruction is taken from copy 0 unless copy 0 reports a failed word, in which case it is taken from copy 1.
- R6: A valid fetch with any error flag set, while no repair runs, raises `scrub_busy` at the next clock edge.
- R7: The repair source is a clean copy if there is one. If both copies report a corrected word, copy 0 is the source and copy 1 the destination. If one copy is corrected and the other failed, the corrected one is the source.
- R8: When both copies report a failed word, `err_uncorr` reads 2'b11 and no repair starts.
- R9: A repair writes every address of the destination with the re-encoded corrected word from the source. Errors at other addresses of either copy are therefore removed from the destination.
- R10: A repair visits one address per two clock cycles. `scrub_busy` stays high for exactly 2*2^ADDR_W cycles and falls after the last address is written.
- R11: Load writes presented while `scrub_busy` is high do not change the store.
- R12: After reset, `scrub_busy` and `instr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for memories and control |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| instr_valid | output | 1 | Fetch result valid, one cycle after the request |
| instr | output | 16 | Corrected instruction word |
| err_corr | output | 2 | Per-copy corrected-error flag, qualified by instr_valid |
| err_uncorr | output | 2 | Per-copy uncorrectable-error flag, qualified by instr_valid |
| scrub_busy | output | 1 | High while a repair walks the memory |
| load_en | input | 1 | Raw codeword write strobe, ignored while scrub_busy |
| load_copy | input | 1 | Copy selected by the load write |
| load_addr | input | ADDR_W | Load write address |
| load_code | input | 22 | Raw codeword in the R1 layout |

## Verification
A fetch result and its flags are due one clock edge after the request edge. The bench drives the request at a falling edge and samples `instr` and the flags at the next falling edge. `scrub_busy` is due one edge later again, so it is checked at the following falling edge. The bench counts how many falling edges see it high and expects exactly 32 for the 16-word configuration. Repair effects are checked only after `scrub_busy` has fallen, by a fresh fetch whose per-copy flags show which copy was rewritten.

// File: rtl/secded_imem_pkg.sv
package secded_imem_pkg;
  localparam int DATA_W = 16;
  localparam int CODE_W = 22;
  localparam int HALF_W = CODE_W / 2;
  localparam int SYN_W  = 5;
  localparam int COPIES = 2;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FAIL  = 2'd2
  } ecc_stat_e;
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_imem_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    int d;
    logic acc;
    code = '0;
    d = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        code[p] = data[d];
        d = d + 1;
      end
    end
    for (int k = 0; k < SYN_W; k++) begin
      acc = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (p[k] && (p != (1 << k))) acc = acc ^ code[p];
      end
      code[1 << k] = acc;
    end
    code[0] = ^code[CODE_W-1:1];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_imem_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output ecc_stat_e         stat
);
  logic [SYN_W-1:0]  syn;
  logic              par;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    int d;
    syn = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (code[p]) syn = syn ^ SYN_W'(p);
    end
    par   = ^code;
    fixed = code;
    if (!par && syn == '0) begin
      stat = ECC_CLEAN;
    end else if (par && syn < SYN_W'(CODE_W)) begin
      stat = ECC_FIXED;
      for (int p = 0; p < CODE_W; p++) begin
        if (SYN_W'(p) == syn) fixed[p] = ~fixed[p];
      end
    end else begin
      stat = ECC_FAIL;
    end
    data = '0;
    d = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        data[d] = fixed[p];
        d = d + 1;
      end
    end
  end
endmodule

// File: rtl/dp_code_bank.sv
module dp_code_bank #(
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 11
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [WIDTH-1:0]  a_q,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [WIDTH-1:0]  b_wd,
  output logic [WIDTH-1:0]  b_q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import secded_imem_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_seen,
  input  ecc_stat_e         stat0,
  input  ecc_stat_e         stat1,
  input  logic [CODE_W-1:0] b_code0,
  input  logic [CODE_W-1:0] b_code1,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              dst,
  output logic              wr_strobe,
  output logic [CODE_W-1:0] wr_code
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'((1 << ADDR_W) - 1);

  typedef enum logic [1:0] {SC_IDLE, SC_READ, SC_WRITE} sc_state_e;
  sc_state_e state;

  logic              any_err, both_fail, start, pick_src;
  logic [CODE_W-1:0] src_code;
  logic [DATA_W-1:0] src_data;
  ecc_stat_e         src_stat;

  assign any_err   = (stat0 != ECC_CLEAN) || (stat1 != ECC_CLEAN);
  assign both_fail = (stat0 == ECC_FAIL) && (stat1 == ECC_FAIL);
  assign start     = fetch_seen && any_err && !both_fail && (state == SC_IDLE);

  always_comb begin
    if (stat0 == ECC_CLEAN)      pick_src = 1'b0;
    else if (stat1 == ECC_CLEAN) pick_src = 1'b1;
    else if (stat0 == ECC_FIXED) pick_src = 1'b0;
    else                         pick_src = 1'b1;
  end

  assign src_code  = dst ? b_code0 : b_code1;
  assign busy      = (state != SC_IDLE);
  assign wr_strobe = (state == SC_WRITE);

  secded_dec u_src_dec (.code(src_code), .data(src_data), .stat(src_stat));
  secded_enc u_src_enc (.data(src_data), .code(wr_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SC_IDLE;
      addr  <= '0;
      dst   <= 1'b0;
    end else begin
      case (state)
        SC_IDLE: if (start) begin
          state <= SC_READ;
          addr  <= '0;
          dst   <= ~pick_src;
        end
        SC_READ: state <= SC_WRITE;
        SC_WRITE: begin
          if (addr == LAST) begin
            state <= SC_IDLE;
          end else begin
            state <= SC_READ;
            addr  <= addr + 1'b1;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  // R10
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_strobe) && busy) |-> (addr == $past(addr) + 1'b1));

  // R7
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dst));
endmodule

// File: rtl/dup_secded_imem.sv
module dup_secded_imem
  import secded_imem_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              instr_valid,
  output logic [15:0]       instr,
  output logic [1:0]        err_corr,
  output logic [1:0]        err_uncorr,
  output logic              scrub_busy,
  input  logic              load_en,
  input  logic              load_copy,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [21:0]       load_code
);
  logic [COPIES-1:0][CODE_W-1:0] a_code, b_code;
  logic [COPIES-1:0][DATA_W-1:0] dec_data;
  ecc_stat_e                     dec_stat [COPIES];

  logic              busy, dst, wr_strobe;
  logic [ADDR_W-1:0] sc_addr, b_addr;
  logic [CODE_W-1:0] sc_code, b_wd;
  logic              valid_q;

  assign b_addr = busy ? sc_addr : load_addr;
  assign b_wd   = busy ? sc_code : load_code;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic we;
    assign we = busy ? (wr_strobe && (dst == 1'(c)))
                     : (load_en && (load_copy == 1'(c)));
    for (genvar h = 0; h < 2; h++) begin : g_half
      dp_code_bank #(.ADDR_W(ADDR_W), .WIDTH(HALF_W)) u_bank (
        .clk    (clk),
        .a_addr (fetch_addr),
        .a_q    (a_code[c][h*HALF_W +: HALF_W]),
        .b_addr (b_addr),
        .b_we   (we),
        .b_wd   (b_wd[h*HALF_W +: HALF_W]),
        .b_q    (b_code[c][h*HALF_W +: HALF_W])
      );
    end
    secded_dec u_dec (.code(a_code[c]), .data(dec_data[c]), .stat(dec_stat[c]));
    assign err_corr[c]   = valid_q && (dec_stat[c] == ECC_FIXED);
    assign err_uncorr[c] = valid_q && (dec_stat[c] == ECC_FAIL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= fetch_valid;
  end

  assign instr_valid = valid_q;
  assign instr       = (dec_stat[0] == ECC_FAIL) ? dec_data[1] : dec_data[0];
  assign scrub_busy  = busy;

  scrub_engine #(.ADDR_W(ADDR_W)) u_scrub (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_seen (valid_q),
    .stat0      (dec_stat[0]),
    .stat1      (dec_stat[1]),
    .b_code0    (b_code[0]),
    .b_code1    (b_code[1]),
    .busy       (busy),
    .addr       (sc_addr),
    .dst        (dst),
    .wr_strobe  (wr_strobe),
    .wr_code    (sc_code)
  );

  // R6
  scrub_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scrub_busy) |-> ($past(instr_valid) && ($past(err_corr) != 2'b00 || $past(err_uncorr) != 2'b00)));

  // R8
  no_fatal_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && err_uncorr == 2'b11 && !scrub_busy) |=> !scrub_busy);
endmodule

// File: tb/tb_dup_secded_imem.sv
module tb_dup_secded_imem;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic instr_valid;
  logic [15:0] instr;
  logic [1:0] err_corr, err_uncorr;
  logic scrub_busy;
  logic load_en = 1'b0;
  logic load_copy = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [21:0] load_code = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dup_secded_imem #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .instr_valid(instr_valid), .instr(instr), .err_corr(err_corr),
    .err_uncorr(err_uncorr), .scrub_busy(scrub_busy), .load_en(load_en),
    .load_copy(load_copy), .load_addr(load_addr), .load_code(load_code)
  );

  function automatic logic [15:0] word_of(input int a);
    return 16'((a * 40503 + 4660) ^ (a << 9));
  endfunction

  // R1 layout, computed as a syndrome over data-bit positions
  function automatic logic [21:0] enc(input logic [15:0] w);
    logic [21:0] c = '0;
    logic [4:0] s = '0;
    int pos = 3;
    for (int i = 0; i < 16; i++) begin
      while (pos == 4 || pos == 8 || pos == 16) pos++;
      if (w[i]) begin
        c[pos] = 1'b1;
        s = s ^ 5'(pos);
      end
      pos++;
    end
    for (int k = 0; k < 5; k++) c[1 << k] = s[k];
    c[0] = ^c;
    return c;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic cp, input int a, input logic [21:0] code);
    @(negedge clk);
    load_en = 1'b1; load_copy = cp; load_addr = AW'(a); load_code = code;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic fetch(input int a);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic check_fetch(input string tag, input int a, input logic [15:0] w,
                             input logic [1:0] corr, input logic [1:0] unc);
    fetch(a);
    chk({tag, " valid"}, 32'(instr_valid), 32'd1);
    chk({tag, " instr"}, 32'(instr), 32'(w));
    chk({tag, " corr"}, 32'(err_corr), 32'(corr));
    chk({tag, " uncorr"}, 32'(err_uncorr), 32'(unc));
  endtask

  task automatic wait_scrub(input string tag, input bit count_it);
    int n = 0;
    @(negedge clk);
    chk({tag, " R6 busy rises"}, 32'(scrub_busy), 32'd1);
    while (scrub_busy) begin
      n++;
      @(negedge clk);
    end
    if (count_it) chk({tag, " R10 busy length"}, 32'(n), 32'(2 * DEPTH));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", 32'(scrub_busy), 32'd0);
    chk("R12 valid", 32'(instr_valid), 32'd0);
    rst_n = 1'b1;

    for (int a = 0; a < DEPTH; a++) begin
      load(1'b0, a, enc(word_of(a)));
      load(1'b1, a, enc(word_of(a)));
    end
    for (int a = 0; a < DEPTH; a++) check_fetch("R1 R2 clean", a, word_of(a), 2'b00, 2'b00);
    @(negedge clk);
    chk("R2 no scrub on clean", 32'(scrub_busy), 32'd0);

    // R3 single flips in every position of each copy, repaired by R9
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 22; b++) begin
        int a = (b + c * 5) % DEPTH;
        load(1'(c), a, enc(word_of(a)) ^ (22'd1 << b));
        check_fetch("R3 single", a, word_of(a), 2'(1 << c), 2'b00);
        wait_scrub("R3", b < 2);
        check_fetch("R9 repaired", a, word_of(a), 2'b00, 2'b00);
      end
    end

    // R4 doubles in each copy
    load(1'b0, 2, enc(word_of(2)) ^ 22'h004008);
    check_fetch("R4 double c0", 2, word_of(2), 2'b00, 2'b01);
    wait_scrub("R4", 1'b1);
    check_fetch("R4 repaired c0", 2, word_of(2), 2'b00, 2'b00);
    load(1'b1, 4, enc(word_of(4)) ^ 22'h300000);
    check_fetch("R4 double c1", 4, word_of(4), 2'b00, 2'b10);
    wait_scrub("R4", 1'b0);
    check_fetch("R4 repaired c1", 4, word_of(4), 2'b00, 2'b00);

    // R5 selection with differing clean contents
    load(1'b1, 5, enc(~word_of(5)));
    check_fetch("R5 copy0 preferred", 5, word_of(5), 2'b00, 2'b00);
    load(1'b0, 5, enc(word_of(5)) ^ 22'h000011);
    check_fetch("R5 copy1 on fail", 5, ~word_of(5), 2'b00, 2'b01);
    wait_scrub("R5", 1'b0);
    load(1'b0, 5, enc(word_of(5)));
    load(1'b1, 5, enc(word_of(5)));
    check_fetch("R5 restored", 5, word_of(5), 2'b00, 2'b00);

    // R7 both single: copy 0 is source
    load(1'b0, 6, enc(word_of(6)) ^ 22'h000010);
    load(1'b1, 6, enc(word_of(6)) ^ 22'h000200);
    check_fetch("R7 both single", 6, word_of(6), 2'b11, 2'b00);
    wait_scrub("R7", 1'b0);
    check_fetch("R7 copy1 rewritten", 6, word_of(6), 2'b01, 2'b00);
    wait_scrub("R7", 1'b0);
    check_fetch("R7 all clean", 6, word_of(6), 2'b00, 2'b00);

    // R7 single vs double: corrected copy is source
    load(1'b0, 7, enc(word_of(7)) ^ 22'h000400);
    load(1'b1, 7, enc(word_of(7)) ^ 22'h000006);
    check_fetch("R7 single vs double", 7, word_of(7), 2'b01, 2'b10);
    wait_scrub("R7", 1'b0);
    check_fetch("R7 failed copy rewritten", 7, word_of(7), 2'b01, 2'b00);
    wait_scrub("R7", 1'b0);
    check_fetch("R7 clean again", 7, word_of(7), 2'b00, 2'b00);

    // R8 both failed: no repair
    load(1'b0, 8, enc(word_of(8)) ^ 22'h000003);
    load(1'b1, 8, enc(word_of(8)) ^ 22'h0C0000);
    fetch(8);
    chk("R8 uncorr both", 32'(err_uncorr), 32'd3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no scrub", 32'(scrub_busy), 32'd0);
    end
    load(1'b0, 8, enc(word_of(8)));
    load(1'b1, 8, enc(word_of(8)));

    // R9 other addresses receive re-encoded corrected words
    load(1'b0, 3, enc(word_of(3)) ^ 22'h000001);
    load(1'b1, 11, enc(word_of(11)) ^ 22'h200000);
    check_fetch("R9 trigger", 3, word_of(3), 2'b01, 2'b00);
    wait_scrub("R9", 1'b0);
    check_fetch("R9 dest re-encoded", 11, word_of(11), 2'b10, 2'b00);
    wait_scrub("R9", 1'b0);
    check_fetch("R9 clean", 11, word_of(11), 2'b00, 2'b00);

    // R11 load ignored during repair (destination is copy 1)
    load(1'b1, 9, enc(word_of(9)) ^ 22'h000080);
    fetch(9);
    repeat (6) @(negedge clk);
    chk("R11 busy during load", 32'(scrub_busy), 32'd1);
    load_en = 1'b1; load_copy = 1'b1; load_addr = '0; load_code = enc(word_of(0)) ^ 22'h000030;
    @(negedge clk);
    load_en = 1'b0;
    while (scrub_busy) @(negedge clk);
    check_fetch("R11 load ignored", 0, word_of(0), 2'b00, 2'b00);

    summary();
    $finish;
  end
endmodule